// File: doc/BRIEF.md
# Lane Receive Buffer with Lock Gating

This block sits between one lane's frame synchronizer and the downstream MAC. Each entry is 65 bits: a 64-bit payload and a control flag that marks control words. The producer pushes entries with a valid strobe and is never stalled. If it pushes into a full buffer, the entry is dropped and a sticky error flag is raised. The consumer pulls entries with a read enable and receives each one a cycle later, together with an output valid strobe.

The block also reports several status flags:
- A partially-empty flag compares the fill level against a threshold input. A consumer may drive its read enable with the inverse of this flag.
- A first-alignment flag records that a synchronization word has left the read side of the buffer.
- A lane lock output is the synchronizer's metaframe lock qualified by the buffer holding data.

A clear input flushes the buffer, but only when it is held for several consecutive cycles. Everything runs in a single clock domain.

Top module: `lane_rx_fifo`

## Requirements
- R1: While reset is low and on the first cycle after it, rd_valid, overflow, align_seen, lock_ok and meta_lock_out are 0, and the buffer is empty.
- R2: A read enable while the buffer holds an entry and no flush is taking place returns the oldest entry on rd_data/rd_ctl in the next cycle, with rd_valid high in that same cycle. Entries leave in the order they were written.
- R3: A write while the buffer holds DEPTH entries is dropped, and the entries already stored are kept. It sets overflow, which stays high until a flush completes.
- R4: A read enable while the buffer is empty gives rd_valid low in the next cycle and leaves the read position unchanged.
- R5: pempty is 1 exactly when the current fill level is below the thresh input. thresh is sampled continuously.
- R6: A clear pulse shorter than CLR_HOLD (default 4) consecutive cycles has no effect on the contents, the fill level or the flags.
- R7: When clr has been high for CLR_HOLD consecutive cycles, the buffer is flushed on that clock edge. Fill and pointers go to zero, and overflow and align_seen clear. While clr stays high the flush repeats and writes and reads are ignored.
- R8: lock_ok is the registered AND of meta_lock_in and a non-empty buffer. In the cycle after the buffer is or becomes empty, lock_ok is 0.
- R9: meta_lock_out is meta_lock_in delayed by one register. Neither meta_lock_out nor align_seen drops because the buffer empties.
- R10: A synchronization word is an entry whose control flag is 1 and whose payload bits [63:58] equal 6'b011110. align_seen is set in the same cycle that such an entry appears on the output with rd_valid. Data words and other control words do not set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Push strobe from the synchronizer |
| wr_data | input | 64 | Payload to store |
| wr_ctl | input | 1 | 1 = control word, 0 = data word |
| rd_en | input | 1 | Read enable from the consumer |
| rd_valid | output | 1 | Output entry valid (one cycle after rd_en) |
| rd_data | output | 64 | Output payload |
| rd_ctl | output | 1 | Output control flag |
| thresh | input | CNT_W | Partially-empty threshold |
| pempty | output | 1 | Fill level below thresh |
| clr | input | 1 | Flush request, must be held CLR_HOLD cycles |
| overflow | output | 1 | Sticky write-into-full error |
| meta_lock_in | input | 1 | Metaframe lock from the synchronizer |
| meta_lock_out | output | 1 | Registered metaframe lock |
| align_seen | output | 1 | First synchronization word has been read out |
| lock_ok | output | 1 | Lane lock: metaframe lock and buffer non-empty |

## Verification
The bench builds the block with DEPTH of 8 and the default CLR_HOLD of 4. The small depth means a full buffer, an overflowing write and a complete drain to empty are all reached within a few dozen cycles. With that depth, the threshold comparison can be shown to change value on a single write. The three-cycle and four-cycle clear pulses show the boundary of the flush filter on both sides.

// File: rtl/lrf_pkg.sv
package lrf_pkg;
  localparam int PAYLOAD_W = 64;
  localparam logic [5:0] SYNC_TAG = 6'b011110;

  typedef struct packed {
    logic                 ctl;
    logic [PAYLOAD_W-1:0] payload;
  } lane_word_t;

  function automatic logic is_sync(input lane_word_t w);
    return w.ctl && (w.payload[PAYLOAD_W-1 -: 6] == SYNC_TAG);
  endfunction
endpackage

// File: rtl/lrf_clr_filter.sv
module lrf_clr_filter #(
  parameter int HOLD = 4,
  localparam int CW = $clog2(HOLD) + 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic flush
);
  logic [CW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                      run_q <= '0;
    else if (!clr)                   run_q <= '0;
    else if (run_q != CW'(HOLD - 1)) run_q <= run_q + 1'b1;
  end

  assign flush = clr && (run_q == CW'(HOLD - 1));
endmodule

// File: rtl/lrf_store.sv
module lrf_store
  import lrf_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       flush,
  input  logic       wr_en,
  input  lane_word_t wr_word,
  input  logic       rd_en,
  output logic       rd_fire,
  output logic       wr_drop,
  output lane_word_t head_word,
  output lane_word_t rd_word,
  output logic       rd_valid,
  output logic [CW-1:0] fill
);
  lane_word_t    mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          full, empty, wr_fire;

  assign full    = (fill == CW'(DEPTH));
  assign empty   = (fill == '0);
  assign wr_fire = wr_en && !full && !flush;
  assign wr_drop = wr_en && full && !flush;
  assign rd_fire = rd_en && !empty && !flush;
  assign head_word = mem[rptr];

  always_ff @(posedge clk) begin
    if (wr_fire) mem[wptr] <= wr_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wptr <= '0;
      rptr <= '0;
      fill <= '0;
    end else begin
      if (wr_fire) wptr <= wptr + 1'b1;
      if (rd_fire) rptr <= rptr + 1'b1;
      case ({wr_fire, rd_fire})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_word  <= '0;
    end else begin
      rd_valid <= rd_fire;
      if (rd_fire) rd_word <= head_word;
    end
  end
endmodule

// File: rtl/lrf_status.sv
module lrf_status
  import lrf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       flush,
  input  logic       wr_drop,
  input  logic       rd_fire,
  input  lane_word_t head_word,
  input  logic       buf_empty,
  input  logic       meta_lock_in,
  output logic       overflow,
  output logic       align_seen,
  output logic       meta_lock_out,
  output logic       lock_ok
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      overflow      <= 1'b0;
      align_seen    <= 1'b0;
      meta_lock_out <= 1'b0;
      lock_ok       <= 1'b0;
    end else begin
      meta_lock_out <= meta_lock_in;
      lock_ok       <= meta_lock_in && !buf_empty;
      if (flush) begin
        overflow   <= 1'b0;
        align_seen <= 1'b0;
      end else begin
        if (wr_drop) overflow <= 1'b1;
        if (rd_fire && is_sync(head_word)) align_seen <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/lane_rx_fifo.sv
module lane_rx_fifo
  import lrf_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int CLR_HOLD = 4,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_valid,
  input  logic [PAYLOAD_W-1:0] wr_data,
  input  logic                 wr_ctl,
  input  logic                 rd_en,
  output logic                 rd_valid,
  output logic [PAYLOAD_W-1:0] rd_data,
  output logic                 rd_ctl,
  input  logic [CNT_W-1:0]     thresh,
  output logic                 pempty,
  input  logic                 clr,
  output logic                 overflow,
  input  logic                 meta_lock_in,
  output logic                 meta_lock_out,
  output logic                 align_seen,
  output logic                 lock_ok
);
  logic             flush, rd_fire, wr_drop;
  lane_word_t       wr_word, head_word, rd_word;
  logic [CNT_W-1:0] fill;

  assign wr_word = '{ctl: wr_ctl, payload: wr_data};

  lrf_clr_filter #(.HOLD(CLR_HOLD)) u_clr (
    .clk(clk), .rst_n(rst_n), .clr(clr), .flush(flush)
  );

  lrf_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .wr_en(wr_valid), .wr_word(wr_word), .rd_en(rd_en),
    .rd_fire(rd_fire), .wr_drop(wr_drop), .head_word(head_word),
    .rd_word(rd_word), .rd_valid(rd_valid), .fill(fill)
  );

  lrf_status u_status (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .wr_drop(wr_drop), .rd_fire(rd_fire), .head_word(head_word),
    .buf_empty(fill == '0), .meta_lock_in(meta_lock_in),
    .overflow(overflow), .align_seen(align_seen),
    .meta_lock_out(meta_lock_out), .lock_ok(lock_ok)
  );

  assign rd_data = rd_word.payload;
  assign rd_ctl  = rd_word.ctl;
  assign pempty  = (fill < thresh);
endmodule

// File: rtl/lrf_checker.sv
module lrf_checker #(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_valid,
  input logic             rd_en,
  input logic             clr,
  input logic             rd_valid,
  input logic             overflow,
  input logic             align_seen,
  input logic             lock_ok,
  input logic [CNT_W-1:0] fill
);
  p_read_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && (fill != '0) && !clr |=> rd_valid);

  p_empty_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && (fill == '0) |=> !rd_valid && (fill <= CNT_W'(1)));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && (fill == CNT_W'(DEPTH)) && !clr |=> overflow);

  p_overflow_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    overflow && !clr |=> overflow);

  p_fill_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CNT_W'(DEPTH));

  p_lock_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fill == '0) |=> !lock_ok);

  p_align_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    align_seen && !clr |=> align_seen);

  p_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr && $past(clr) && $past(clr, 2) && $past(clr, 3) |=> (fill == '0) && !overflow && !align_seen);
endmodule

bind lane_rx_fifo lrf_checker #(.DEPTH(DEPTH)) i_lrf_checker (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .rd_en(rd_en), .clr(clr),
  .rd_valid(rd_valid), .overflow(overflow), .align_seen(align_seen),
  .lock_ok(lock_ok), .fill(fill)
);

// File: tb/test_lane_rx_fifo.sv
`timescale 1ns/1ps
module test_lane_rx_fifo;
  localparam int DEPTH = 8;
  localparam int CNT_W = $clog2(DEPTH) + 1;

  // {ctl, payload}; entry 2 is the only synchronization word (R10)
  localparam logic [64:0] VEC [8] = '{
    {1'b0, 6'b011110, 58'h0000_0000_0000_0A1},
    {1'b1, 6'b000001, 58'h0000_0000_0000_0B2},
    {1'b1, 6'b011110, 58'h0000_0000_0000_0C3},
    {1'b0, 64'h1234_5678_9ABC_DEF0},
    {1'b1, 64'h0F0F_F0F0_1111_2222},
    {1'b0, 64'hFFFF_FFFF_FFFF_FFFF},
    {1'b0, 64'h0000_0000_0000_0000},
    {1'b1, 64'hA5A5_5A5A_C3C3_3C3C}
  };

  logic clk = 1'b0;
  logic rst_n, wr_valid, wr_ctl, rd_en, clr, meta_lock_in;
  logic [63:0] wr_data, rd_data;
  logic [CNT_W-1:0] thresh;
  logic rd_valid, rd_ctl, pempty, overflow, meta_lock_out, align_seen, lock_ok;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  lane_rx_fifo #(.DEPTH(DEPTH)) i_lane_rx_fifo (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_ctl(wr_ctl), .rd_en(rd_en), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_ctl(rd_ctl), .thresh(thresh), .pempty(pempty), .clr(clr),
    .overflow(overflow), .meta_lock_in(meta_lock_in),
    .meta_lock_out(meta_lock_out), .align_seen(align_seen), .lock_ok(lock_ok)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [64:0] act, input logic [64:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_valid = 1'b0; wr_ctl = 1'b0; wr_data = '0;
    rd_en = 1'b0; clr = 1'b0; meta_lock_in = 1'b0; thresh = CNT_W'(2);
    repeat (3) step();
    rst_n = 1'b1;
    step();
    chk("R1 rd_valid", rd_valid, 0);
    chk("R1 overflow", overflow, 0);
    chk("R1 align_seen", align_seen, 0);
    chk("R1 lock_ok", lock_ok, 0);
    chk("R1 meta_lock_out", meta_lock_out, 0);
    chk("R1 pempty", pempty, 1);

    meta_lock_in = 1'b1;
    step(); step();
    chk("R9 meta_lock_out follows", meta_lock_out, 1);
    chk("R8 lock_ok low while empty", lock_ok, 0);

    for (int i = 0; i < DEPTH; i++) begin
      wr_valid = 1'b1; wr_ctl = VEC[i][64]; wr_data = VEC[i][63:0];
      step();
    end
    wr_ctl = 1'b0; wr_data = 64'hDEAD_BEEF_DEAD_BEEF;
    step();
    wr_valid = 1'b0;
    chk("R3 overflow set", overflow, 1);
    chk("R8 lock_ok with data", lock_ok, 1);
    chk("R5 pempty above thresh", pempty, 0);

    rd_en = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin
      step();
      chk("R2 rd_valid", rd_valid, 1);
      chk("R2 R3 entry order", {rd_ctl, rd_data}, VEC[i]);
      if (i == 1) chk("R10 non-sync control word", align_seen, 0);
      if (i == 2) chk("R10 sync word read out", align_seen, 1);
    end
    step();
    chk("R4 empty read no valid", rd_valid, 0);
    chk("R8 lock_ok drops after empty", lock_ok, 0);
    chk("R9 meta_lock_out held", meta_lock_out, 1);
    chk("R9 align_seen held", align_seen, 1);
    chk("R3 overflow sticky", overflow, 1);
    rd_en = 1'b0;

    thresh = CNT_W'(3);
    for (int i = 3; i < 6; i++) begin
      wr_valid = 1'b1; wr_ctl = VEC[i][64]; wr_data = VEC[i][63:0];
      step();
      if (i == 4) chk("R5 pempty below thresh", pempty, 1);
      if (i == 5) chk("R5 pempty at thresh", pempty, 0);
    end
    wr_valid = 1'b0;

    clr = 1'b1;
    repeat (3) step();
    clr = 1'b0;
    step();
    chk("R6 short clear keeps overflow", overflow, 1);
    chk("R6 short clear keeps fill", pempty, 0);
    rd_en = 1'b1;
    step();
    rd_en = 1'b0;
    chk("R6 short clear data kept", {rd_valid, rd_ctl, rd_data}, {1'b1, VEC[3]});
    chk("R4 R2 read pointer intact", align_seen, 1);

    clr = 1'b1;
    repeat (4) step();
    clr = 1'b0;
    chk("R7 flush clears overflow", overflow, 0);
    chk("R7 flush clears align_seen", align_seen, 0);
    chk("R7 flush empties", pempty, 1);
    step();
    chk("R8 lock_ok low after flush", lock_ok, 0);
    rd_en = 1'b1;
    step();
    rd_en = 1'b0;
    chk("R7 no data after flush", rd_valid, 0);

    wr_valid = 1'b1; wr_ctl = VEC[7][64]; wr_data = VEC[7][63:0];
    step();
    wr_valid = 1'b0;
    rd_en = 1'b1;
    step();
    rd_en = 1'b0;
    chk("R7 pointers reset", {rd_valid, rd_ctl, rd_data}, {1'b1, VEC[7]});

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule